// File: doc/BRIEF.md
# Second-Chance Frame Victim Selector

This block picks which physical page frame to reclaim when a new page must be brought in. It keeps one resident flag and one recently-used flag per frame, plus a rotating pointer that walks the frames in ring order. Accesses to resident frames mark them as recently used. Filling a frame marks it resident and recently used.

When a victim is requested, an empty frame is returned at once if one exists. The lowest-numbered empty frame wins. Otherwise the pointer starts walking, one frame per clock. A frame still marked recently used loses its mark and is passed over. The first frame found unmarked becomes the victim, and the pointer then rests on the frame after it. The surrounding paging logic moves the page data and updates the translation tables. It then reports the fill through the load input.

Top module: `clock_victim_picker`

## Requirements
- R1: Reset leaves every frame non-resident and unmarked, the pointer (`hand_o`) at 0, `busy_o` low and `vdone_o` low.
- R2: A request accepted while any frame is non-resident returns the lowest-numbered non-resident frame. `vdone_o` rises in the cycle after the accepting edge, and the pointer does not move.
- R3: During a walk, if the frame under the pointer is unmarked and not being accessed or loaded in that cycle, it is returned as the victim.
- R4: During a walk, a marked frame under the pointer has its mark cleared and is skipped. A later walk that reaches it again can then choose it.
- R5: An access (`acc_valid_i`) to a resident frame marks it, so the next walk skips that frame.
- R6: A load (`load_valid_i`) makes its frame resident and marks it.
- R7: The pointer advances by exactly one frame, modulo the frame count, on every clock of a walk. With all frames marked and no concurrent traffic, `vdone_o` rises NUM_FRAMES+1 clocks after the accepting edge, and the victim is the frame where the walk began.
- R8: When a walk returns frame v, the pointer afterwards reads (v+1) modulo NUM_FRAMES.
- R9: If the frame under the pointer is accessed in the same clock the walk would clear its mark, the mark stays set, that frame is not chosen, and the pointer advances.
- R10: `vdone_o` is a one-clock pulse that answers exactly one accepted request. Requests made while `busy_o` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Active-low synchronous reset |
| acc_valid_i | input | 1 | A resident frame is being accessed |
| acc_frame_i | input | $clog2(NUM_FRAMES) | Index of the accessed frame |
| load_valid_i | input | 1 | A frame has just been filled |
| load_frame_i | input | $clog2(NUM_FRAMES) | Index of the filled frame |
| vreq_i | input | 1 | Request a victim; accepted when `busy_o` is low |
| busy_o | output | 1 | A walk is in progress |
| vdone_o | output | 1 | One-clock pulse: `vframe_o` holds the chosen frame |
| vframe_o | output | $clog2(NUM_FRAMES) | Chosen victim frame index |
| hand_o | output | $clog2(NUM_FRAMES) | Current pointer position |

## Verification
The hardest situation to reach is an access landing on the frame under the pointer in exactly the clock the walk inspects it. Its effect is also invisible until a later walk comes back around to that frame. The stimulus first marks the frame, starts a walk on it, and raises the access one clock after the accepting edge. It then marks every other frame so that the next walk has to travel all the way around. That walk must skip the contested frame once more, so the victim differs from the one a design without the set-over-clear priority would return. Walks that start with every frame marked are timed from the accepting edge to check the NUM_FRAMES+1 bound and the wrap of the pointer.

// File: rtl/clock_victim_pkg.sv
package clock_victim_pkg;

   typedef enum logic [0:0] {
      WALK_IDLE  = 1'b0,
      WALK_SCAN  = 1'b1
   } walk_state_e;

endpackage

// File: rtl/frame_flag_array.sv
module frame_flag_array #(
   parameter int NUM_FRAMES = 8,
   parameter int IW         = $clog2(NUM_FRAMES)
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  ld_en_i,
   input  logic [IW-1:0]         ld_idx_i,
   input  logic                  acc_en_i,
   input  logic [IW-1:0]         acc_idx_i,
   input  logic                  clr_en_i,
   input  logic [IW-1:0]         clr_idx_i,
   output logic [NUM_FRAMES-1:0] resident_o,
   output logic [NUM_FRAMES-1:0] marked_o
);

   for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_frame
      logic res_q;
      logic mark_q;
      logic ld_hit;
      logic acc_hit;
      logic clr_hit;

      assign ld_hit  = ld_en_i  && (ld_idx_i  == IW'(g));
      assign acc_hit = acc_en_i && (acc_idx_i == IW'(g)) && res_q;
      assign clr_hit = clr_en_i && (clr_idx_i == IW'(g));

      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            res_q  <= 1'b0;
            mark_q <= 1'b0;
         end else begin
            if (ld_hit) begin
               res_q <= 1'b1;
            end
            // setting always beats the walk's clear
            if (ld_hit || acc_hit) begin
               mark_q <= 1'b1;
            end else if (clr_hit) begin
               mark_q <= 1'b0;
            end
         end
      end

      assign resident_o[g] = res_q;
      assign marked_o[g]   = mark_q;
   end

endmodule

// File: rtl/free_frame_finder.sv
module free_frame_finder #(
   parameter int NUM_FRAMES = 8,
   parameter int IW         = $clog2(NUM_FRAMES)
) (
   input  logic [NUM_FRAMES-1:0] resident_i,
   output logic                  any_free_o,
   output logic [IW-1:0]         free_idx_o
);

   always_comb begin
      any_free_o = 1'b0;
      free_idx_o = '0;
      // scan downward so the lowest empty frame is the last one written
      for (int i = NUM_FRAMES - 1; i >= 0; i--) begin
         if (!resident_i[i]) begin
            any_free_o = 1'b1;
            free_idx_o = IW'(i);
         end
      end
   end

endmodule

// File: rtl/ring_pointer.sv
module ring_pointer #(
   parameter int NUM_FRAMES = 8,
   parameter int IW         = $clog2(NUM_FRAMES)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          step_i,
   output logic [IW-1:0] ptr_o
);

   localparam bit          IS_POW2 = (NUM_FRAMES & (NUM_FRAMES - 1)) == 0;
   localparam logic [IW-1:0] LAST  = IW'(NUM_FRAMES - 1);

   logic [IW-1:0] ptr_q;
   logic [IW-1:0] ptr_next;

   if (IS_POW2) begin : g_wrap_free
      assign ptr_next = ptr_q + 1'b1;
   end else begin : g_wrap_cmp
      assign ptr_next = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         ptr_q <= '0;
      end else if (step_i) begin
         ptr_q <= ptr_next;
      end
   end

   assign ptr_o = ptr_q;

endmodule

// File: rtl/clock_victim_picker.sv
module clock_victim_picker
   import clock_victim_pkg::*;
#(
   parameter int NUM_FRAMES = 8,
   localparam int IW        = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          acc_valid_i,
   input  logic [IW-1:0] acc_frame_i,
   input  logic          load_valid_i,
   input  logic [IW-1:0] load_frame_i,
   input  logic          vreq_i,
   output logic          busy_o,
   output logic          vdone_o,
   output logic [IW-1:0] vframe_o,
   output logic [IW-1:0] hand_o
);

   if (NUM_FRAMES < 2) begin : g_bad_frames
      $error("clock_victim_picker: NUM_FRAMES must be at least 2");
   end

   walk_state_e           state_q;
   logic                  done_q;
   logic [IW-1:0]         frame_q;
   logic [NUM_FRAMES-1:0] resident;
   logic [NUM_FRAMES-1:0] marked;
   logic                  any_free;
   logic [IW-1:0]         free_idx;
   logic [IW-1:0]         hand;
   logic                  scanning;
   logic                  touch_now;
   logic                  hand_in_use;

   assign scanning = (state_q == WALK_SCAN);

   // traffic on the frame under the pointer in this very clock
   assign touch_now = (acc_valid_i  && (acc_frame_i  == hand) && resident[hand])
                    || (load_valid_i && (load_frame_i == hand));
   assign hand_in_use = marked[hand] || touch_now;

   frame_flag_array #(.NUM_FRAMES(NUM_FRAMES), .IW(IW)) i_flags (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ld_en_i    (load_valid_i),
      .ld_idx_i   (load_frame_i),
      .acc_en_i   (acc_valid_i),
      .acc_idx_i  (acc_frame_i),
      .clr_en_i   (scanning && marked[hand]),
      .clr_idx_i  (hand),
      .resident_o (resident),
      .marked_o   (marked)
   );

   free_frame_finder #(.NUM_FRAMES(NUM_FRAMES), .IW(IW)) i_free (
      .resident_i (resident),
      .any_free_o (any_free),
      .free_idx_o (free_idx)
   );

   ring_pointer #(.NUM_FRAMES(NUM_FRAMES), .IW(IW)) i_hand (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .step_i (scanning),
      .ptr_o  (hand)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q <= WALK_IDLE;
         done_q  <= 1'b0;
         frame_q <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            WALK_IDLE: begin
               if (vreq_i) begin
                  if (any_free) begin
                     done_q  <= 1'b1;
                     frame_q <= free_idx;
                  end else begin
                     state_q <= WALK_SCAN;
                  end
               end
            end
            WALK_SCAN: begin
               if (!hand_in_use) begin
                  done_q  <= 1'b1;
                  frame_q <= hand;
                  state_q <= WALK_IDLE;
               end
            end
            default: state_q <= WALK_IDLE;
         endcase
      end
   end

   assign busy_o   = scanning;
   assign vdone_o  = done_q;
   assign vframe_o = frame_q;
   assign hand_o   = hand;

endmodule

// File: rtl/clock_victim_picker_chk.sv
module clock_victim_picker_chk #(
   parameter int NUM_FRAMES = 8,
   localparam int IW        = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic          acc_valid_i,
   input logic [IW-1:0] acc_frame_i,
   input logic          vreq_i,
   input logic          busy_o,
   input logic          vdone_o,
   input logic [IW-1:0] vframe_o,
   input logic [IW-1:0] hand_o
);

   function automatic logic [IW-1:0] step_of(input logic [IW-1:0] v);
      return (v == IW'(NUM_FRAMES - 1)) ? '0 : v + 1'b1;
   endfunction

   logic rst_prev_n;
   always_ff @(posedge clk_i) rst_prev_n <= rst_ni;

   // R1
   always @(posedge clk_i) begin
      if (!rst_ni && !rst_prev_n) begin
         reset_state_chk: assert (!busy_o && !vdone_o && hand_o == '0);
      end
   end

   // R2
   idle_hand_still_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o |=> $stable(hand_o));

   // R7
   walk_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o |=> hand_o == step_of($past(hand_o)));

   // R8
   hand_after_victim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vdone_o && $past(busy_o)) |-> hand_o == step_of(vframe_o));

   // R9
   touched_not_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && acc_valid_i && acc_frame_i == hand_o)
      |=> !(vdone_o && vframe_o == $past(hand_o)));

   // R10
   done_has_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vdone_o |-> ($past(busy_o) || $past(vreq_i)));

   // R10
   done_ends_walk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vdone_o && $past(busy_o)) |-> !busy_o);

endmodule

bind clock_victim_picker clock_victim_picker_chk #(.NUM_FRAMES(NUM_FRAMES)) i_chk (.*);

// File: tb/test_clock_victim_picker.sv
module test_clock_victim_picker;

   localparam int CLK_PERIOD = 10;
   localparam int N          = 8;
   localparam int IW         = $clog2(N);
   localparam int WATCHDOG   = 20000;
   localparam int NV         = 23;

   // op codes: 0 load, 1 access, 2 request
   // entry = {op[1:0], frame[3:0], expected victim[3:0], expected hand[3:0]}
   localparam logic [13:0] VEC [NV] = '{
      {2'd2, 4'd0, 4'd0, 4'd0},   // R2 all empty -> 0
      {2'd0, 4'd0, 4'd0, 4'd0},
      {2'd0, 4'd3, 4'd0, 4'd0},
      {2'd2, 4'd0, 4'd1, 4'd0},   // R2 lowest empty is 1
      {2'd0, 4'd1, 4'd0, 4'd0},   // R6 loads fill the rest
      {2'd0, 4'd2, 4'd0, 4'd0},
      {2'd0, 4'd4, 4'd0, 4'd0},
      {2'd0, 4'd5, 4'd0, 4'd0},
      {2'd0, 4'd6, 4'd0, 4'd0},
      {2'd0, 4'd7, 4'd0, 4'd0},
      {2'd2, 4'd0, 4'd0, 4'd1},   // R7 R4 full lap, back to 0
      {2'd2, 4'd0, 4'd1, 4'd2},   // R3 R8
      {2'd1, 4'd2, 4'd0, 4'd0},   // R5
      {2'd1, 4'd3, 4'd0, 4'd0},
      {2'd2, 4'd0, 4'd4, 4'd5},   // R5 R4 skips 2 and 3
      {2'd2, 4'd0, 4'd5, 4'd6},
      {2'd1, 4'd7, 4'd0, 4'd0},
      {2'd2, 4'd0, 4'd6, 4'd7},
      {2'd2, 4'd0, 4'd0, 4'd1},   // R8 wrap past 7
      {2'd2, 4'd0, 4'd1, 4'd2},
      {2'd2, 4'd0, 4'd2, 4'd3},
      {2'd0, 4'd3, 4'd0, 4'd0},   // R6 reload marks 3
      {2'd2, 4'd0, 4'd4, 4'd5}
   };

   logic          clk = 1'b0;
   logic          rst_n;
   logic          acc_valid;
   logic [IW-1:0] acc_frame;
   logic          load_valid;
   logic [IW-1:0] load_frame;
   logic          vreq;
   logic          busy;
   logic          vdone;
   logic [IW-1:0] vframe;
   logic [IW-1:0] hand;

   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   clock_victim_picker #(.NUM_FRAMES(N)) i_clock_victim_picker (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .acc_valid_i  (acc_valid),
      .acc_frame_i  (acc_frame),
      .load_valid_i (load_valid),
      .load_frame_i (load_frame),
      .vreq_i       (vreq),
      .busy_o       (busy),
      .vdone_o      (vdone),
      .vframe_o     (vframe),
      .hand_o       (hand)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic do_load(input int f);
      @(negedge clk);
      load_valid = 1'b1;
      load_frame = IW'(f);
      @(negedge clk);
      load_valid = 1'b0;
   endtask

   task automatic do_access(input int f);
      @(negedge clk);
      acc_valid = 1'b1;
      acc_frame = IW'(f);
      @(negedge clk);
      acc_valid = 1'b0;
   endtask

   // issue one request; optionally touch a frame or re-request one clock after acceptance
   task automatic do_req(input bit extra_acc, input int acc_f, input bit extra_req,
                         output int frm, output int hnd, output int lat);
      @(negedge clk);
      vreq = 1'b1;
      @(posedge clk);
      @(negedge clk);
      vreq = 1'b0;
      if (extra_acc) begin
         acc_valid = 1'b1;
         acc_frame = IW'(acc_f);
      end
      if (extra_req) vreq = 1'b1;
      lat = 0;
      while (!vdone && lat < 64) begin
         @(posedge clk);
         lat++;
         @(negedge clk);
         acc_valid = 1'b0;
         vreq      = 1'b0;
      end
      acc_valid = 1'b0;
      vreq      = 1'b0;
      frm = int'(vframe);
      hnd = int'(hand);
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", WATCHDOG, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      int frm, hnd, lat, extra;
      rst_n = 1'b0; acc_valid = 1'b0; acc_frame = '0;
      load_valid = 1'b0; load_frame = '0; vreq = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 busy", int'(busy), 0);
      check("R1 done", int'(vdone), 0);
      check("R1 hand", int'(hand), 0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         logic [1:0] op;
         int f, ef, eh;
         op = VEC[i][13:12];
         f  = int'(VEC[i][11:8]);
         ef = int'(VEC[i][7:4]);
         eh = int'(VEC[i][3:0]);
         case (op)
            2'd0: do_load(f);
            2'd1: do_access(f);
            default: begin
               do_req(1'b0, 0, 1'b0, frm, hnd, lat);
               check($sformatf("R3/R8 row %0d victim", i), frm, ef);
               check($sformatf("R3/R8 row %0d hand", i), hnd, eh);
            end
         endcase
      end

      // R9: access frame 5 in the clock the walk inspects it
      do_access(5);
      do_req(1'b1, 5, 1'b0, frm, hnd, lat);
      check("R9 first victim", frm, 6);
      check("R9 first hand", hnd, 7);
      for (int f = 0; f < 5; f++) do_access(f);
      do_access(7);
      do_req(1'b0, 0, 1'b0, frm, hnd, lat);
      check("R9 kept mark skips 5", frm, 6);
      check("R9 second hand", hnd, 7);

      // R7: every frame marked, walk starts at 7
      for (int f = 0; f < N; f++) do_access(f);
      do_req(1'b0, 0, 1'b0, frm, hnd, lat);
      check("R7 latency", lat, N + 1);
      check("R7 victim", frm, 7);
      check("R7 hand wrap", hnd, 0);

      // R10: second request during the walk is ignored
      for (int f = 0; f < N; f++) do_access(f);
      do_req(1'b0, 0, 1'b1, frm, hnd, lat);
      check("R10 victim", frm, 0);
      check("R10 latency", lat, N + 1);
      extra = 0;
      for (int c = 0; c < 12; c++) begin
         @(negedge clk);
         if (vdone || busy) extra++;
      end
      check("R10 no extra answer", extra, 0);

      // R1: reset in mid-life empties all frames
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R1 re-reset hand", int'(hand), 0);
      rst_n = 1'b1;
      do_req(1'b0, 0, 1'b0, frm, hnd, lat);
      check("R1 frames empty after reset", frm, 0);
      check("R2 immediate latency", lat, 0);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule